// File: doc/BRIEF.md
# Banked Memory Management Unit

This unit sits between an 8-bit CPU bus and a 32-bit physical address space. It holds a small register file: a configuration byte that picks one of four banks and sets the ROM, RAM and I/O overlays; four preset bytes that replace the configuration in a single write; a common-RAM sharing control; zero-page and stack-page relocation pointers; and a 16-bit page index for each bank. Each page index selects one 64 KB page, so the four banks can each sit anywhere in a 4 GB space.

Register accesses complete on the clock edge. Translation is purely combinational. For every CPU address the unit produces a 32-bit physical address and a 2-bit region tag, and it flags accesses that land on its own registers. The tag encodes RAM = 0, internal ROM = 1, external ROM = 2 and I/O = 3. The bus fabric routes the access using the tag. Two mode bits go out to the rest of the system: the processor select and the operating-system select.

Top module: `bank_mmu`

## Requirements
- R1: After reset, the configuration byte and all four presets read 0, the page index of bank b is b, sharing is off, the zero-page pointer is 0x0000, the stack pointer is 0x0001 and both mode outputs are 0.
- R2: When the processor select is 0, a write of any data to $FF01, $FF02, $FF03 or $FF04 copies preset A, B, C or D into the configuration byte, and the new value is visible from the following cycle.
- R3: When the processor select (mode bit 0) is 0, addresses $FF00-$FF04 hit the registers in every bank and under every overlay, with tag I/O, and $FF00 reads and writes the configuration byte. When the processor select is 1, these addresses are translated like any other address and writes to them change no register.
- R4: When configuration bit 0 is 1, the registers are also at $D500 + offset. The offsets are: 0 configuration, 1-4 presets A-D, 5 sharing, 6 mode, 7 version, 8+2b and 9+2b the low and high page bytes of bank b, 16/17 zero-page pointer low/high, 18/19 stack pointer low/high. When configuration bit 0 is 0, $D500 is not a register.
- R5: When configuration bit 0 is 1, addresses $D000-$DFFF that are not registers get tag I/O with physical address {16'h0, addr}. When the bit is 0, no address outside the register hits gets tag I/O.
- R6: The ROM windows are $4000-$7FFF (configuration bit 1: 0 system ROM, 1 RAM), $8000-$BFFF (bits 3-2) and $C000-$FFFF (bits 5-4). For bits 3-2 and 5-4 the codes are 00 system ROM, 01 internal ROM, 10 external ROM and 11 RAM. System ROM gives tag 1 and {16'h0, addr}. Internal ROM gives tag 1 and {15'h0, 1'b1, addr}. External ROM gives tag 2 and {16'h0, addr}.
- R7: A RAM access outside sharing and relocation maps to {page[bank], addr}, where bank is configuration bits 7-6.
- R8: Sharing byte bits 3-2 select the shared area (0 none, 1 top, 2 bottom, 3 both). Bits 1-0 select its size (0 = 1K, 1 = 4K, 2 = 8K, 3 = 16K). A RAM access inside a shared area maps to {page[0], addr}, and this takes precedence over relocation.
- R9: A RAM access to CPU page $00 maps to {8'h0, zero-page pointer, addr[7:0]}, and an access to page $01 maps to {8'h0, stack pointer, addr[7:0]}.
- R10: A read of $FF01-$FF04 returns the stored preset and leaves the configuration byte unchanged.
- R11: The version register reads {BANK_CODE, MMU_VER}, by default 0xF2, and ignores writes.
- R12: Mode register bit 0 drives `cpu32_mode` and bit 6 drives `os_alt_mode`. The register reads back as written and changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | CPU access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data (0 when no register is hit) |
| reg_hit | output | 1 | Address selects a unit register |
| phys_addr | output | 32 | Translated physical address |
| region | output | 2 | Region tag: 0 RAM, 1 internal ROM, 2 external ROM, 3 I/O |
| cpu32_mode | output | 1 | Processor select (mode bit 0) |
| os_alt_mode | output | 1 | Operating-system select (mode bit 6) |

## Verification
On every cycle the embedded properties check four things: a preset load through a trigger write, the stability of the configuration byte across reads, the stability of the mode byte when it is not written, and the absence of an I/O tag while the I/O overlay is off. They also check the zero-page mapping while sharing is off and the bank-0 mapping of the bottom shared area. The scenarios exercise the other behaviours. These are the full priority order between register hits, the I/O window, ROM windows, sharing and relocation, and the exact boundaries of each shared size. They also cover the loss of the $FF00-$FF04 window in 32-bit mode and the refusal of version writes.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int NBANKS  = 4;
    localparam int PAGE_W  = 16;
    localparam int PHYS_W  = PAGE_W + 16;
    localparam int NPRE    = 4;
    localparam int REG_CNT = 20;
    localparam int IDX_W   = $clog2(REG_CNT);

    localparam int OFS_CFG  = 0;
    localparam int OFS_PRE  = 1;
    localparam int OFS_SHR  = 5;
    localparam int OFS_MODE = 6;
    localparam int OFS_VER  = 7;
    localparam int OFS_PG   = 8;
    localparam int OFS_ZP   = 16;
    localparam int OFS_SP   = 18;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_ROMI = 2'd1,
        RGN_ROME = 2'd2,
        RGN_IO   = 2'd3
    } region_t;
endpackage

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_pkg::*;
#(
    parameter logic [3:0] BANK_CODE = 4'hF,
    parameter logic [3:0] MMU_VER   = 4'h2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_we,
    input  logic [15:0]                  bus_addr,
    input  logic [7:0]                   bus_wdata,
    output logic [7:0]                   rdata,
    output logic                         reg_hit,
    output logic [7:0]                   cfg,
    output logic [3:0]                   ramcfg,
    output logic [PAGE_W-1:0]            zp_page,
    output logic [PAGE_W-1:0]            sp_page,
    output logic [NBANKS-1:0][PAGE_W-1:0] bank_page,
    output logic                         cpu32,
    output logic                         os_alt
);
    logic [7:0]        cfg_q, mode_q;
    logic [7:0]        pre_q [NPRE];
    logic [3:0]        shr_q;
    logic [PAGE_W-1:0] zp_q, sp_q;
    logic [PAGE_W-1:0] pg_q [NBANKS];

    logic             ff_win, io_win, wr, trig;
    logic [IDX_W-1:0] idx;
    logic [1:0]       pidx;
    logic [7:0]       pre_sel;

    assign ff_win  = !mode_q[0] && (bus_addr[15:8] == 8'hFF) && (bus_addr[7:0] <= 8'h04);
    assign io_win  = cfg_q[0] && (bus_addr[15:8] == 8'hD5) && (bus_addr[7:0] < 8'(REG_CNT));
    assign reg_hit = ff_win || io_win;
    assign idx     = ff_win ? {2'b00, bus_addr[2:0]} : bus_addr[IDX_W-1:0];
    assign wr      = bus_valid && bus_we && reg_hit;
    assign trig    = wr && ff_win && (idx != IDX_W'(OFS_CFG));
    assign pidx    = 2'(bus_addr[2:0] - 3'd1);
    assign pre_sel = pre_q[pidx];

    always_ff @(posedge clk) begin
        if (!rst_n)                                cfg_q <= '0;
        else if (trig)                             cfg_q <= pre_sel;
        else if (wr && idx == IDX_W'(OFS_CFG))     cfg_q <= bus_wdata;
    end

    for (genvar p = 0; p < NPRE; p++) begin : g_pre
        always_ff @(posedge clk) begin
            if (!rst_n)
                pre_q[p] <= '0;
            else if (wr && !ff_win && idx == IDX_W'(OFS_PRE + p))
                pre_q[p] <= bus_wdata;
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n)
                pg_q[b] <= PAGE_W'(b);
            else if (wr && idx == IDX_W'(OFS_PG + 2*b))
                pg_q[b][7:0] <= bus_wdata;
            else if (wr && idx == IDX_W'(OFS_PG + 2*b + 1))
                pg_q[b][15:8] <= bus_wdata;
        end
        assign bank_page[b] = pg_q[b];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q  <= '0;
            mode_q <= '0;
            zp_q   <= PAGE_W'(0);
            sp_q   <= PAGE_W'(1);
        end else if (wr) begin
            case (idx)
                IDX_W'(OFS_SHR):    shr_q       <= bus_wdata[3:0];
                IDX_W'(OFS_MODE):   mode_q      <= bus_wdata;
                IDX_W'(OFS_ZP):     zp_q[7:0]   <= bus_wdata;
                IDX_W'(OFS_ZP + 1): zp_q[15:8]  <= bus_wdata;
                IDX_W'(OFS_SP):     sp_q[7:0]   <= bus_wdata;
                IDX_W'(OFS_SP + 1): sp_q[15:8]  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_hit) begin
            if (idx == IDX_W'(OFS_CFG))        rdata = cfg_q;
            if (idx == IDX_W'(OFS_SHR))        rdata = {4'h0, shr_q};
            if (idx == IDX_W'(OFS_MODE))       rdata = mode_q;
            if (idx == IDX_W'(OFS_VER))        rdata = {BANK_CODE, MMU_VER};
            if (idx == IDX_W'(OFS_ZP))         rdata = zp_q[7:0];
            if (idx == IDX_W'(OFS_ZP + 1))     rdata = zp_q[15:8];
            if (idx == IDX_W'(OFS_SP))         rdata = sp_q[7:0];
            if (idx == IDX_W'(OFS_SP + 1))     rdata = sp_q[15:8];
            for (int p = 0; p < NPRE; p++)
                if (idx == IDX_W'(OFS_PRE + p)) rdata = pre_q[p];
            for (int b = 0; b < NBANKS; b++) begin
                if (idx == IDX_W'(OFS_PG + 2*b))     rdata = pg_q[b][7:0];
                if (idx == IDX_W'(OFS_PG + 2*b + 1)) rdata = pg_q[b][15:8];
            end
        end
    end

    assign cfg     = cfg_q;
    assign ramcfg  = shr_q;
    assign zp_page = zp_q;
    assign sp_page = sp_q;
    assign cpu32   = mode_q[0];
    assign os_alt  = mode_q[6];

    // R2
    trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cfg_q == $past(pre_sel)));

    // R10
    rd_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> $stable(cfg_q));

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == IDX_W'(OFS_MODE)) |=> $stable(mode_q));
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [15:0]                   cpu_addr,
    input  logic                          reg_hit,
    input  logic [7:0]                    cfg,
    input  logic [3:0]                    ramcfg,
    input  logic [PAGE_W-1:0]             zp_page,
    input  logic [PAGE_W-1:0]             sp_page,
    input  logic [NBANKS-1:0][PAGE_W-1:0] bank_page,
    output logic [PHYS_W-1:0]             phys_addr,
    output region_t                       region
);
    localparam int PAD_W = PHYS_W - PAGE_W - 8;

    logic [16:0] share_sz;
    logic        bot_hit, top_hit;
    logic [1:0]  wcode;

    always_comb begin
        unique case (ramcfg[1:0])
            2'd0: share_sz = 17'h00400;
            2'd1: share_sz = 17'h01000;
            2'd2: share_sz = 17'h02000;
            2'd3: share_sz = 17'h04000;
        endcase
    end

    assign bot_hit = ramcfg[3] && ({1'b0, cpu_addr} < share_sz);
    assign top_hit = ramcfg[2] && ({1'b0, ~cpu_addr} < share_sz);

    always_comb begin
        unique case (cpu_addr[15:14])
            2'b00: wcode = 2'b11;
            2'b01: wcode = cfg[1] ? 2'b11 : 2'b00;
            2'b10: wcode = cfg[3:2];
            2'b11: wcode = cfg[5:4];
        endcase
    end

    always_comb begin
        region    = RGN_RAM;
        phys_addr = {bank_page[cfg[7:6]], cpu_addr};
        if (reg_hit || (cfg[0] && cpu_addr[15:12] == 4'hD)) begin
            region    = RGN_IO;
            phys_addr = {{PAGE_W{1'b0}}, cpu_addr};
        end else if (wcode != 2'b11) begin
            region    = (wcode == 2'b10) ? RGN_ROME : RGN_ROMI;
            phys_addr = {{(PAGE_W-1){1'b0}}, (wcode == 2'b01), cpu_addr};
        end else if (bot_hit || top_hit) begin
            phys_addr = {bank_page[0], cpu_addr};
        end else if (cpu_addr[15:8] == 8'h00) begin
            phys_addr = {{PAD_W{1'b0}}, zp_page, cpu_addr[7:0]};
        end else if (cpu_addr[15:8] == 8'h01) begin
            phys_addr = {{PAD_W{1'b0}}, sp_page, cpu_addr[7:0]};
        end
    end

    // R5
    io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[0] && !reg_hit) |-> (region != RGN_IO));

    // R9
    zp_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_RAM && cpu_addr[15:8] == 8'h00 && ramcfg[3:2] == 2'b00)
        |-> (phys_addr[PHYS_W-1:PHYS_W-PAD_W] == '0 && phys_addr[7:0] == cpu_addr[7:0]
             && phys_addr[PAGE_W+7:8] == zp_page));

    // R8
    share_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_RAM && ramcfg[3] && cpu_addr < 16'h0400)
        |-> (phys_addr[PHYS_W-1:16] == bank_page[0]));
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import mmu_pkg::*;
#(
    parameter logic [3:0] BANK_CODE = 4'hF,
    parameter logic [3:0] MMU_VER   = 4'h2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        reg_hit,
    output logic [31:0] phys_addr,
    output logic [1:0]  region,
    output logic        cpu32_mode,
    output logic        os_alt_mode
);
    logic [7:0]                   cfg;
    logic [3:0]                   ramcfg;
    logic [PAGE_W-1:0]            zp_page, sp_page;
    logic [NBANKS-1:0][PAGE_W-1:0] bank_page;
    region_t                      rgn;

    mmu_regfile #(.BANK_CODE(BANK_CODE), .MMU_VER(MMU_VER)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rdata(bus_rdata),
        .reg_hit(reg_hit), .cfg(cfg), .ramcfg(ramcfg), .zp_page(zp_page),
        .sp_page(sp_page), .bank_page(bank_page), .cpu32(cpu32_mode),
        .os_alt(os_alt_mode)
    );

    mmu_xlate u_xlate (
        .clk(clk), .rst_n(rst_n), .cpu_addr(bus_addr), .reg_hit(reg_hit),
        .cfg(cfg), .ramcfg(ramcfg), .zp_page(zp_page), .sp_page(sp_page),
        .bank_page(bank_page), .phys_addr(phys_addr), .region(rgn)
    );

    assign region = rgn;
endmodule

// File: tb/sim_bank_mmu.sv
module sim_bank_mmu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        reg_hit;
    logic [31:0] phys_addr;
    logic [1:0]  region;
    logic        cpu32_mode, os_alt_mode;

    localparam logic [1:0] T_RAM = 2'd0, T_ROMI = 2'd1, T_ROME = 2'd2, T_IO = 2'd3;

    always #5 clk = ~clk;

    bank_mmu u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reg_hit(reg_hit), .phys_addr(phys_addr), .region(region),
        .cpu32_mode(cpu32_mode), .os_alt_mode(os_alt_mode)
    );

    typedef struct {
        int          kind;
        logic [31:0] ephys;
        logic [1:0]  ergn;
        logic        ehit;
        logic [7:0]  edata;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.kind = 1; it.edata = e; it.tag = tag;
        it.ephys = '0; it.ergn = '0; it.ehit = 1'b0;
        q.push_back(it);
    endtask

    task automatic xl(input logic [15:0] a, input logic [31:0] ep, input logic [1:0] eg,
                      input logic eh, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_addr = a;
        it.kind = 0; it.ephys = ep; it.ergn = eg; it.ehit = eh; it.tag = tag; it.edata = '0;
        q.push_back(it);
    endtask

    task automatic md(input logic e32, input logic eos, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = 1'b0;
        it.kind = 2; it.ephys = {30'h0, e32, eos}; it.ergn = '0; it.ehit = 1'b0;
        it.edata = '0; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.kind == 0) begin
                    if (phys_addr !== it.ephys || region !== it.ergn || reg_hit !== it.ehit) begin
                        errors++;
                        $display("FAIL %s addr=%h: got phys=%h rgn=%0d hit=%0b exp phys=%h rgn=%0d hit=%0b",
                                 it.tag, bus_addr, phys_addr, region, reg_hit,
                                 it.ephys, it.ergn, it.ehit);
                    end
                end else if (it.kind == 1) begin
                    if (bus_rdata !== it.edata) begin
                        errors++;
                        $display("FAIL %s addr=%h: got rdata=%h exp %h", it.tag, bus_addr,
                                 bus_rdata, it.edata);
                    end
                end else begin
                    if ({cpu32_mode, os_alt_mode} !== it.ephys[1:0]) begin
                        errors++;
                        $display("FAIL %s: got cpu32/os=%b%b exp %b", it.tag, cpu32_mode,
                                 os_alt_mode, it.ephys[1:0]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(16'hFF00, 8'h00, "R1 cfg reset");
        rd(16'hFF03, 8'h00, "R1 preset C reset");
        xl(16'h2000, 32'h0000_2000, T_RAM, 1'b0, "R1 bank0 page reset");
        xl(16'h0050, 32'h0000_0050, T_RAM, 1'b0, "R1 zp reset");
        xl(16'h0150, 32'h0000_0150, T_RAM, 1'b0, "R1 sp reset");
        md(1'b0, 1'b0, "R1 mode reset");
        // R6 system ROM at reset, R5 io off, R4 no register at D500
        xl(16'hC000, 32'h0000_C000, T_ROMI, 1'b0, "R6 high sys rom");
        xl(16'h4000, 32'h0000_4000, T_ROMI, 1'b0, "R6 low sys rom");
        xl(16'hD000, 32'h0000_D000, T_ROMI, 1'b0, "R5 io off");
        xl(16'hD500, 32'h0000_D500, T_ROMI, 1'b0, "R4 regs hidden");
        xl(16'hFF00, 32'h0000_FF00, T_IO, 1'b1, "R3 FF00 visible");
        xl(16'hFF05, 32'h0000_FF05, T_ROMI, 1'b0, "R3 FF05 not reg");

        wr(16'hFF00, 8'h7F);
        rd(16'hFF00, 8'h7F, "R3 FF00 write");
        xl(16'hD500, 32'h0000_D500, T_IO, 1'b1, "R4 regs at D500");
        xl(16'hD123, 32'h0000_D123, T_IO, 1'b0, "R5 io window");
        xl(16'hDFFF, 32'h0000_DFFF, T_IO, 1'b0, "R5 io top");
        xl(16'hE000, 32'h0001_E000, T_RAM, 1'b0, "R1 bank1 page reset");
        rd(16'hD50C, 8'h02, "R1 bank2 lo reset");
        rd(16'hD50D, 8'h00, "R1 bank2 hi reset");

        wr(16'hD50A, 8'h34);
        wr(16'hD50B, 8'h12);
        rd(16'hD50B, 8'h12, "R4 page hi readback");
        xl(16'h8123, 32'h1234_8123, T_RAM, 1'b0, "R7 bank1 map");
        xl(16'h4000, 32'h1234_4000, T_RAM, 1'b0, "R7 low window ram");

        wr(16'hD501, 8'h7E);
        wr(16'hD502, 8'hE4);
        rd(16'hD502, 8'hE4, "R4 preset B readback");
        wr(16'hFF02, 8'h55);
        rd(16'hFF00, 8'hE4, "R2 load preset B");
        xl(16'hC100, 32'h0000_C100, T_ROME, 1'b0, "R6 high ext rom");
        xl(16'h8000, 32'h0001_8000, T_ROMI, 1'b0, "R6 mid int rom");
        xl(16'h4000, 32'h0000_4000, T_ROMI, 1'b0, "R6 low sys rom");
        xl(16'h2000, 32'h0003_2000, T_RAM, 1'b0, "R7 bank3 reset page");
        xl(16'hD500, 32'h0000_D500, T_ROME, 1'b0, "R4 io off hides regs");
        xl(16'hFF04, 32'h0000_FF04, T_IO, 1'b1, "R3 FF04 under rom");

        wr(16'hFF00, 8'h7F);
        rd(16'hFF02, 8'hE4, "R10 read preset B");
        rd(16'hFF00, 8'h7F, "R10 no load on read");
        wr(16'hFF01, 8'h00);
        rd(16'hFF00, 8'h7E, "R2 load preset A");
        xl(16'hD000, 32'h1234_D000, T_RAM, 1'b0, "R5 io off gives ram");
        wr(16'hFF00, 8'h7F);

        wr(16'hD510, 8'h77);
        wr(16'hD511, 8'h07);
        wr(16'hD512, 8'h0B);
        wr(16'hD513, 8'h0A);
        xl(16'h0050, 32'h0007_7750, T_RAM, 1'b0, "R9 zp reloc");
        xl(16'h01FF, 32'h000A_0BFF, T_RAM, 1'b0, "R9 sp reloc");
        xl(16'h0200, 32'h1234_0200, T_RAM, 1'b0, "R7 page 2 unrelocated");

        wr(16'hD505, 8'h05);
        xl(16'hF800, 32'h0000_F800, T_RAM, 1'b0, "R8 top 4K");
        xl(16'hF000, 32'h0000_F000, T_RAM, 1'b0, "R8 top 4K edge");
        xl(16'hEFFF, 32'h1234_EFFF, T_RAM, 1'b0, "R8 below top area");
        xl(16'hFF03, 32'h0000_FF03, T_IO, 1'b1, "R3 reg beats share");
        xl(16'hFF10, 32'h0000_FF10, T_RAM, 1'b0, "R8 top share FF10");

        wr(16'hD505, 8'h08);
        xl(16'h0050, 32'h0000_0050, T_RAM, 1'b0, "R8 share beats zp");
        xl(16'h03FF, 32'h0000_03FF, T_RAM, 1'b0, "R8 bottom 1K edge");
        xl(16'h0400, 32'h1234_0400, T_RAM, 1'b0, "R8 above bottom 1K");
        xl(16'hF800, 32'h1234_F800, T_RAM, 1'b0, "R8 top off");

        wr(16'hD505, 8'h0F);
        xl(16'h3FFF, 32'h0000_3FFF, T_RAM, 1'b0, "R8 both 16K low");
        xl(16'hC000, 32'h0000_C000, T_RAM, 1'b0, "R8 both 16K high");
        xl(16'h4000, 32'h1234_4000, T_RAM, 1'b0, "R8 16K boundary");
        rd(16'hD505, 8'h0F, "R8 share readback");
        wr(16'hD505, 8'h00);

        rd(16'hD507, 8'hF2, "R11 version");
        wr(16'hD507, 8'h00);
        rd(16'hD507, 8'hF2, "R11 version write ignored");

        wr(16'hD506, 8'h41);
        md(1'b1, 1'b1, "R12 mode outputs");
        rd(16'hD506, 8'h41, "R12 mode readback");
        xl(16'hFF02, 32'h1234_FF02, T_RAM, 1'b0, "R3 FF02 not reg in 32-bit");
        wr(16'hFF02, 8'h99);
        rd(16'hD500, 8'h7F, "R3 no trigger in 32-bit");
        wr(16'hD506, 8'h00);
        md(1'b0, 1'b0, "R12 mode cleared");
        xl(16'hFF02, 32'h0000_FF02, T_IO, 1'b1, "R3 FF02 reg again");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule